// File: doc/BRIEF.md
# Audio Link Sample FIFO Port

This block sits between a 32-bit host register bus and the sample path of an audio serial link controller. It has two queues of 16 samples each. The transmit queue is loaded by host writes and drained by the link serializer. The receive queue is loaded by the serializer and drained by host reads. A run-time payload length between 8 and 20 bits sets which low data bits are meaningful. Bits above that length are cleared on the way into the transmit queue and on the way out of the receive queue.

A write to a full transmit queue is discarded, and a read from an empty receive queue is flagged. Each of these sets its own sticky event, which is cleared by writing 1. Both queues have a level-based request flag. A direct-mode control bit decides how those flags are used. With direct mode off, they drive DMA handshake outputs. With direct mode on, they appear as interrupt events for program-controlled transfers. One interrupt line carries the OR of the unmasked events.

The register map uses word address `bus_addr`:
- 0 is the sample data register.
- 1 is control: bits 4:0 payload length, bit 8 direct mode, bits 19:16 event mask.
- 2 is status, which is read-only: bit 0 transmit request, bit 1 receive request, bits 12:8 transmit level, bits 20:16 receive level.
- 3 is events: bit 0 transmit overflow, bit 1 receive underflow, bit 2 transmit request, bit 3 receive request.

Read data appears on `bus_rdata` one clock after the read strobe.

Top module: `audio_fifo_port`

## Requirements
- R1: After reset, both queues are empty and all events are 0. The irq and DMA request outputs are low (`dma_tx_req` rises one cycle later because the empty transmit queue requests). Control reads 0x000F0010: length 16, direct mode off, all four mask bits (19:16) set.
- R2: A host write to address 0 appends bits 19:0 of the word, with bits at and above the payload length forced to 0, to the transmit queue. `link_tx_data` shows the oldest entry and `link_tx_valid` is high while the queue is not empty. A `link_tx_pop` strobe removes the oldest entry, so entries come out in write order.
- R3: A host write to address 0 while the transmit queue holds 16 entries and `link_tx_pop` is low is discarded. It leaves the queue contents unchanged and sets event bit 0. The level never exceeds 16.
- R4: A host write to address 0 in the same cycle as a `link_tx_pop` on a full transmit queue is accepted. It becomes the newest entry, the level stays 16, and event bit 0 is not set.
- R5: A host read of address 0 removes the oldest receive entry and returns it with all bits at and above the payload length equal to 0. Entries come out in push order.
- R6: A host read of address 0 while the receive queue is empty returns 0 and sets event bit 1.
- R7: Writing address 3 clears event bits 0 and 1 wherever the written bit is 1. Bits written as 0 are left unchanged.
- R8: A length written to control bits 4:0 is clamped to the range 8..20 and reads back clamped.
- R9: Status bit 0 is 1 when the transmit level is 8 or fewer. Status bit 1 is 1 when the receive level is 8 or more. Writes to address 2 have no effect.
- R10: With direct mode 0, `dma_tx_req`/`dma_rx_req` follow the transmit and receive request flags one cycle later, and event bits 2 and 3 read 0. With direct mode 1, both DMA outputs are 0 and event bits 2 and 3 equal the request flags.
- R11: `irq` is 1 exactly one cycle after any event bit is 1 whose mask bit (control bit 16 + event index) is 0.
- R12: A `link_rx_push` while the receive queue holds 16 entries and no host read of address 0 occurs is dropped. `link_rx_full` is high while the queue holds 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| link_tx_pop | input | 1 | Serializer takes the oldest transmit sample |
| link_tx_data | output | 20 | Oldest transmit sample |
| link_tx_valid | output | 1 | Transmit queue not empty |
| link_rx_push | input | 1 | Serializer delivers a received sample |
| link_rx_data | input | 20 | Received sample |
| link_rx_full | output | 1 | Receive queue holds 16 entries |
| dma_tx_req | output | 1 | Transmit DMA request, registered |
| dma_rx_req | output | 1 | Receive DMA request, registered |
| irq | output | 1 | OR of unmasked events, registered |

## Verification
The assertions assume that `link_tx_pop` is only strobed while `link_tx_valid` is high. They also assume that `link_rx_push` does not arrive on a full receive queue except where the drop rule is the case under test. Finally, they assume that a bus access lasts exactly one cycle, so one strobe is one push or one pop.

The bench raises every strobe for a single cycle and pops the transmit queue only after writes have filled it. It drives the receive side to exactly 16 entries before the extra push that must be dropped.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

  localparam int SMP_W   = 20;
  localparam int BUS_W   = 32;
  localparam int LEN_W   = 5;
  localparam int LEN_MIN = 8;
  localparam int LEN_MAX = 20;
  localparam int NUM_EVT = 4;

  typedef enum logic [1:0] {
    RG_SAMPLE = 2'd0,
    RG_CTRL   = 2'd1,
    RG_STAT   = 2'd2,
    RG_EVENT  = 2'd3
  } reg_addr_e;

  // event bit positions
  localparam int EV_TXOVF = 0;
  localparam int EV_RXUNF = 1;
  localparam int EV_TXREQ = 2;
  localparam int EV_RXREQ = 3;

  // mask keeping the low 'len' bits of a sample
  function automatic logic [SMP_W-1:0] keep_mask(input logic [LEN_W-1:0] len);
    logic [SMP_W-1:0] m;
    for (int i = 0; i < SMP_W; i++) begin
      m[i] = (i < int'(len));
    end
    return m;
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (int'(v) < LEN_MIN)      return LEN_W'(LEN_MIN);
    else if (int'(v) > LEN_MAX) return LEN_W'(LEN_MAX);
    else                        return v;
  endfunction

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr);
      if (pop_ok)  rptr <= step(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/evt_unit.sv
module evt_unit
  import audio_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         sticky_set,
  input  logic [1:0]         sticky_clr,
  input  logic               tx_req,
  input  logic               rx_req,
  input  logic               direct,
  input  logic [NUM_EVT-1:0] mask,
  output logic [NUM_EVT-1:0] evt,
  output logic               irq
);

  logic [1:0] sticky_q;

  for (genvar g = 0; g < 2; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)                sticky_q[g] <= 1'b0;
      else if (sticky_set[g]) sticky_q[g] <= 1'b1;
      else if (sticky_clr[g]) sticky_q[g] <= 1'b0;
    end
  end

  always_comb begin
    evt           = '0;
    evt[EV_TXOVF] = sticky_q[0];
    evt[EV_RXUNF] = sticky_q[1];
    evt[EV_TXREQ] = tx_req & direct;
    evt[EV_RXREQ] = rx_req & direct;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt & ~mask);
  end

endmodule

// File: rtl/audio_fifo_port.sv
module audio_fifo_port
  import audio_port_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TX_THRESH = 8,
  parameter int RX_THRESH = 8,
  parameter int LEN_RESET = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             link_tx_pop,
  output logic [SMP_W-1:0] link_tx_data,
  output logic             link_tx_valid,
  input  logic             link_rx_push,
  input  logic [SMP_W-1:0] link_rx_data,
  output logic             link_rx_full,
  output logic             dma_tx_req,
  output logic             dma_rx_req,
  output logic             irq
);

  localparam int LW = $clog2(DEPTH + 1);

  // control register fields
  logic [LEN_W-1:0]   ctrl_len;
  logic               ctrl_direct;
  logic [NUM_EVT-1:0] ctrl_mask;

  // bus decode
  logic wr_access, rd_access;
  logic tx_push_try, rx_pop_try;
  assign wr_access   = bus_sel &  bus_we;
  assign rd_access   = bus_sel & ~bus_we;
  assign tx_push_try = wr_access & (bus_addr == RG_SAMPLE);
  assign rx_pop_try  = rd_access & (bus_addr == RG_SAMPLE);

  logic [SMP_W-1:0] len_keep;
  assign len_keep = keep_mask(ctrl_len);

  // queues
  logic [SMP_W-1:0] tx_head, rx_head;
  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;

  sample_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .push      (tx_push_try),
    .push_data (bus_wdata[SMP_W-1:0] & len_keep),
    .pop       (link_tx_pop),
    .head      (tx_head),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  sample_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .push      (link_rx_push),
    .push_data (link_rx_data),
    .pop       (rx_pop_try),
    .head      (rx_head),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign link_tx_data  = tx_head;
  assign link_tx_valid = ~tx_empty;
  assign link_rx_full  = rx_full;

  // request flags
  logic tx_req, rx_req;
  assign tx_req = (tx_level <= LW'(TX_THRESH));
  assign rx_req = (rx_level >= LW'(RX_THRESH));

  // events
  logic               tx_ovf, rx_unf;
  logic [1:0]         evt_clr;
  logic [NUM_EVT-1:0] evt;
  assign tx_ovf  = tx_push_try & tx_full & ~link_tx_pop;
  assign rx_unf  = rx_pop_try & rx_empty;
  assign evt_clr = (wr_access && bus_addr == RG_EVENT) ?
                   bus_wdata[EV_RXUNF:EV_TXOVF] : 2'b00;

  evt_unit u_evt (
    .clk        (clk),
    .rst        (rst),
    .sticky_set ({rx_unf, tx_ovf}),
    .sticky_clr (evt_clr),
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .direct     (ctrl_direct),
    .mask       (ctrl_mask),
    .evt        (evt),
    .irq        (irq)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_len    <= LEN_W'(LEN_RESET);
      ctrl_direct <= 1'b0;
      ctrl_mask   <= '1;
    end else if (wr_access && bus_addr == RG_CTRL) begin
      ctrl_len    <= clamp_len(bus_wdata[LEN_W-1:0]);
      ctrl_direct <= bus_wdata[8];
      ctrl_mask   <= bus_wdata[16 +: NUM_EVT];
    end
  end

  // DMA handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
    end else begin
      dma_tx_req <= tx_req & ~ctrl_direct;
      dma_rx_req <= rx_req & ~ctrl_direct;
    end
  end

  // read mux
  logic [BUS_W-1:0] ctrl_word, stat_word, evt_word, rd_word;
  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[LEN_W-1:0]      = ctrl_len;
    ctrl_word[8]              = ctrl_direct;
    ctrl_word[16 +: NUM_EVT]  = ctrl_mask;
    stat_word                 = '0;
    stat_word[0]              = tx_req;
    stat_word[1]              = rx_req;
    stat_word[8 +: LW]        = tx_level;
    stat_word[16 +: LW]       = rx_level;
    evt_word                  = '0;
    evt_word[NUM_EVT-1:0]     = evt;
    case (bus_addr)
      RG_SAMPLE: rd_word = rx_empty ? '0 : BUS_W'(rx_head & len_keep);
      RG_CTRL:   rd_word = ctrl_word;
      RG_STAT:   rd_word = stat_word;
      default:   rd_word = evt_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (rd_access) bus_rdata <= rd_word;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[BUS_W-1:SMP_W], bus_wdata[7:LEN_W],
                         bus_wdata[15:9], rx_full};

endmodule

// File: rtl/audio_fifo_port_chk.sv
module audio_fifo_port_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_push_try,
  input logic          link_tx_pop,
  input logic          tx_full,
  input logic [LW-1:0] tx_level,
  input logic          rx_pop_try,
  input logic [LW-1:0] rx_level,
  input logic [3:0]    evt,
  input logic [3:0]    ctrl_mask,
  input logic          ctrl_direct,
  input logic          irq,
  input logic          dma_tx_req,
  input logic          dma_rx_req
);

  assert_tx_level_R3: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(evt[0]) |-> $past(tx_push_try && tx_full && !link_tx_pop));

  assert_full_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_push_try && tx_full && link_tx_pop) |=> (tx_full && !$rose(evt[0])));

  assert_unf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(evt[1]) |-> $past(rx_pop_try && rx_level == '0));

  assert_dma_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_direct) |-> (!dma_tx_req && !dma_rx_req));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(evt & ~ctrl_mask)));

  assert_rx_level_R12: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LW'(DEPTH));

endmodule

bind audio_fifo_port audio_fifo_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_push_try (tx_push_try),
  .link_tx_pop (link_tx_pop),
  .tx_full     (tx_full),
  .tx_level    (tx_level),
  .rx_pop_try  (rx_pop_try),
  .rx_level    (rx_level),
  .evt         (evt),
  .ctrl_mask   (ctrl_mask),
  .ctrl_direct (ctrl_direct),
  .irq         (irq),
  .dma_tx_req  (dma_tx_req),
  .dma_rx_req  (dma_rx_req)
);

// File: tb/tb_audio_fifo_port.sv
`timescale 1ns/1ps
module tb_audio_fifo_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        link_tx_pop = 1'b0;
  logic [19:0] link_tx_data;
  logic        link_tx_valid;
  logic        link_rx_push = 1'b0;
  logic [19:0] link_rx_data = '0;
  logic        link_rx_full, dma_tx_req, dma_rx_req, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  audio_fifo_port dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .link_tx_pop(link_tx_pop), .link_tx_data(link_tx_data),
    .link_tx_valid(link_tx_valid), .link_rx_push(link_rx_push),
    .link_rx_data(link_rx_data), .link_rx_full(link_rx_full),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t TBL [0:11] = '{
    '{1'b0, 2'd1, 32'h000F0014, 32'h0},          // R8 length 20
    '{1'b0, 2'd0, 32'hFFF12345, 32'h0},          // R2 push
    '{1'b1, 2'd1, 32'h0,        32'h000F0014},   // R8
    '{1'b0, 2'd1, 32'h000F0003, 32'h0},          // R8 below range
    '{1'b1, 2'd1, 32'h0,        32'h000F0008},   // R8
    '{1'b0, 2'd0, 32'h0000ABCD, 32'h0},          // R2 push at length 8
    '{1'b0, 2'd1, 32'h000F001F, 32'h0},          // R8 above range
    '{1'b1, 2'd1, 32'h0,        32'h000F0014},   // R8
    '{1'b1, 2'd2, 32'h0,        32'h00000201},   // R9 level 2
    '{1'b0, 2'd2, 32'hFFFFFFFF, 32'h0},          // R9 write ignored
    '{1'b1, 2'd2, 32'h0,        32'h00000201},   // R9
    '{1'b1, 2'd3, 32'h0,        32'h00000000}    // R10 events clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tx_pop(output logic [19:0] d);
    @(negedge clk);
    d = link_tx_data;
    link_tx_pop = 1'b1;
    @(negedge clk);
    link_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [19:0] d);
    @(negedge clk);
    link_rx_push = 1'b1; link_rx_data = d;
    @(negedge clk);
    link_rx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [19:0] p;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx valid", {31'b0, link_tx_valid}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx full", {31'b0, link_rx_full}, 32'h0);
    rd_chk("R1 ctrl", 2'd1, 32'h000F0010);
    rd_chk("R1 events", 2'd3, 32'h0);
    rd_chk("R1 status", 2'd2, 32'h00000001);

    // table walk (R2, R8, R9, R10)
    for (int i = 0; i < 12; i++) begin
      if (TBL[i].rd) begin
        rd(TBL[i].addr, v);
        checks++;
        if (v !== TBL[i].exp) begin
          errors++;
          $display("FAIL table row %0d (R8/R9/R10) actual=%h expected=%h", i, v, TBL[i].exp);
        end
      end else begin
        wr(TBL[i].addr, TBL[i].data);
      end
    end

    // R2 order and masking at push
    tx_pop(p); chk("R2 first sample", {12'b0, p}, 32'h00012345);
    tx_pop(p); chk("R2 second masked", {12'b0, p}, 32'h000000CD);
    chk("R2 drained", {31'b0, link_tx_valid}, 32'h0);

    // R3 overflow
    for (int i = 0; i < 16; i++) wr(2'd0, 32'hF0A00 + i);
    wr(2'd0, 32'h77777);
    rd_chk("R3 status full", 2'd2, 32'h00001000);
    rd_chk("R3 event set", 2'd3, 32'h00000001);
    for (int i = 0; i < 16; i++) begin
      tx_pop(p);
      chk("R3 contents", {12'b0, p}, 32'hF0A00 + i);
    end
    chk("R3 dropped write", {31'b0, link_tx_valid}, 32'h0);

    // R7 write-1-clear
    wr(2'd3, 32'h0);
    rd_chk("R7 zero keeps", 2'd3, 32'h1);
    wr(2'd3, 32'h1);
    rd_chk("R7 one clears", 2'd3, 32'h0);

    // R4 push with pop on full
    for (int i = 0; i < 16; i++) wr(2'd0, 32'h200 + i);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h999;
    link_tx_pop = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; link_tx_pop = 1'b0;
    rd_chk("R4 no overflow", 2'd3, 32'h0);
    rd_chk("R4 level 16", 2'd2, 32'h00001000);
    for (int i = 0; i < 15; i++) tx_pop(p);
    tx_pop(p);
    chk("R4 newest accepted", {12'b0, p}, 32'h00000999);

    // R5 read with zero fill, length 12
    wr(2'd1, 32'h000F000C);
    rx_push(20'hFFFFF);
    rx_push(20'h12345);
    rd_chk("R5 first", 2'd0, 32'h00000FFF);
    rd_chk("R5 second", 2'd0, 32'h00000345);

    // R6 underflow
    rd_chk("R6 empty data", 2'd0, 32'h0);
    rd_chk("R6 event", 2'd3, 32'h00000002);
    wr(2'd3, 32'h2);
    rd_chk("R7 clear underflow", 2'd3, 32'h0);

    // R9 receive request threshold
    for (int i = 0; i < 7; i++) rx_push(20'h100 + i);
    rd_chk("R9 rx level 7", 2'd2, 32'h00070001);
    rx_push(20'h107);
    rd_chk("R9 rx level 8", 2'd2, 32'h00080003);

    // R12 full receive queue
    for (int i = 8; i < 16; i++) rx_push(20'h100 + i);
    chk("R12 full flag", {31'b0, link_rx_full}, 32'h1);
    rx_push(20'h1AB);
    rd_chk("R12 level held", 2'd2, 32'h00100003);
    for (int i = 0; i < 16; i++) rd_chk("R12 contents", 2'd0, 32'h100 + i);
    rd_chk("R12 no underflow", 2'd3, 32'h0);

    // R10 DMA vs direct mode
    for (int i = 0; i < 8; i++) rx_push(20'h40 + i);
    repeat (2) @(negedge clk);
    chk("R10 dma tx", {31'b0, dma_tx_req}, 32'h1);
    chk("R10 dma rx", {31'b0, dma_rx_req}, 32'h1);
    wr(2'd1, 32'h000F010C);
    repeat (2) @(negedge clk);
    chk("R10 direct dma tx", {31'b0, dma_tx_req}, 32'h0);
    chk("R10 direct dma rx", {31'b0, dma_rx_req}, 32'h0);
    rd_chk("R10 request events", 2'd3, 32'h0000000C);

    // R11 interrupt masking
    chk("R11 all masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h000B010C);
    repeat (2) @(negedge clk);
    chk("R11 unmasked request", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h000E000C);
    repeat (2) @(negedge clk);
    chk("R11 masked again", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 17; i++) wr(2'd0, 32'h5);
    repeat (2) @(negedge clk);
    chk("R11 overflow irq", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h1);
    repeat (2) @(negedge clk);
    chk("R11 cleared irq", {31'b0, irq}, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule